// File: doc/BRIEF.md
# Non-Overlapping 101 Sequence Detector

This block watches a single serial input, taking one bit on each rising clock edge, and raises a flag when the bits 1, 0, 1 have arrived in that order. It is a Moore machine: the flag is decoded from the held state alone, so it appears in the cycle after the edge that captured the final 1 and stays up for exactly that one cycle.

Matches never share bits. Once a match is reported, its closing 1 may not act as the opening 1 of the next match. A new match has to be built from the bits that follow. For the stream 1,0,1,0,1 the flag rises after the third bit and stays low after the fifth.

The machine has four states held in two bits, and every code is used: idle = 00, seen "1" = 01, seen "10" = 10, found = 11. A synchronous, active-high reset returns it to idle.

Top module: `seq101_det`

## Requirements
- R1: While `rst` is high at a rising edge, the machine moves to idle whatever `din` holds. `hit` is 0 in the cycle that follows.
- R2: `hit` is 1 only in the found state (code 11). It is high in the cycle after an edge that completed 1,0,1, and low in every other cycle.
- R3: In idle, a 0 on `din` keeps the machine in idle, so a run of zeros never raises `hit`.
- R4: In the seen-"1" state, a further 1 keeps the machine in seen-"1". The stream 1,1,0,1 therefore raises `hit` after its fourth bit.
- R5: In the seen-"10" state, a 0 sends the machine back to idle. The stream 1,0,0,1 never raises `hit`.
- R6: Detection never overlaps. From found, a 1 moves to seen-"1" and a 0 moves to idle. The stream 1,0,1,0,1 raises `hit` after bit 3 and not after bit 5, and 1,0,1,0,1,0,1 raises it after bits 3 and 7.
- R7: `hit` never stays high for two cycles in a row.
- R8: A reset in the middle of a pattern discards the partial match. A later 1,0,1 is still detected in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one input bit is taken per edge |
| rst | input | 1 | Synchronous reset, active high, returns the machine to idle |
| din | input | 1 | Serial data bit |
| hit | output | 1 | High for one cycle in the state that follows a completed 1,0,1 |

## Verification
The block has no parameters, so the bench builds it exactly as it is delivered, and all four state codes and all eight state/input transitions can be reached. A fixed 16-bit stream and its hand-derived flags cover the non-overlap rule, self-loops in seen-"1", and the fall back to idle from seen-"10". A long run of random bits is then compared, cycle by cycle, with a model that tracks how many bits have arrived since the last match, which is a different formulation from the state machine's. Directed tests cover reset with the input held at 1, reset in the middle of a pattern, long runs of zeros, and the isolated one-cycle flag.

// File: rtl/seq101_det.sv
module seq101_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_ONE   = 2'b01,
    S_ONE0  = 2'b10,
    S_FOUND = 2'b11
  } state_t;

  state_t cur, nxt;

  always_comb begin
    case (cur)
      S_IDLE:  nxt = din ? S_ONE   : S_IDLE;
      S_ONE:   nxt = din ? S_ONE   : S_ONE0;
      S_ONE0:  nxt = din ? S_FOUND : S_IDLE;
      default: nxt = din ? S_ONE   : S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= S_IDLE;
    else     cur <= nxt;
  end

  assign hit = (cur == S_FOUND);

endmodule

// File: rtl/seq101_det_chk.sv
module seq101_det_chk (
  input logic clk,
  input logic rst,
  input logic din,
  input logic hit
);

  p_pulse_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  p_last_bit_one_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(din));

  p_middle_bit_zero_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> !$past(din, 2));

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> ##2 !hit);

endmodule

bind seq101_det seq101_det_chk u_chk (
  .clk(clk),
  .rst(rst),
  .din(din),
  .hit(hit)
);

// File: tb/sim_seq101_det.sv
module sim_seq101_det;

  localparam time CLK_PERIOD = 10ns;
  localparam int  TBL_LEN    = 16;
  localparam int  RAND_BITS  = 3000;
  localparam int  WATCHDOG   = 200000;

  localparam bit STIM [TBL_LEN] = '{1,0,1,0,1,0,1,1,0,0,1,1,0,1,0,0};
  localparam bit EXPV [TBL_LEN] = '{0,0,1,0,0,0,1,0,0,0,0,0,0,1,0,0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  seq101_det u0 (.clk(clk), .rst(rst), .din(din), .hit(hit));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit expv, input string req);
    n_checks++;
    if (hit !== expv) begin
      n_fail++;
      $display("FAIL %s: hit=%b expected=%b at %0t", req, hit, expv, $time);
    end
  endtask

  task automatic push(input bit b, input bit expv, input string req);
    din = b;
    @(posedge clk);
    @(negedge clk);
    check(expv, req);
  endtask

  task automatic do_reset(input bit hold);
    rst = 1'b1;
    din = hold;
    @(posedge clk);
    @(negedge clk);
    check(1'b0, "R1");
    rst = 1'b0;
  endtask

  int since_match;
  logic [2:0] last3;

  initial begin
    @(negedge clk);
    do_reset(1'b1);
    do_reset(1'b1);

    for (int i = 0; i < TBL_LEN; i++)
      push(STIM[i], EXPV[i], "R6 table");

    for (int i = 0; i < 20; i++) push(1'b0, 1'b0, "R3 zeros");

    push(1'b1, 1'b0, "R4"); push(1'b1, 1'b0, "R4");
    push(1'b0, 1'b0, "R4"); push(1'b1, 1'b1, "R4 hit after 1101");
    push(1'b1, 1'b0, "R7 single cycle");

    push(1'b0, 1'b0, "R3"); push(1'b0, 1'b0, "R3");
    push(1'b1, 1'b0, "R5"); push(1'b0, 1'b0, "R5");
    push(1'b0, 1'b0, "R5"); push(1'b1, 1'b0, "R5 1001 no hit");
    push(1'b0, 1'b0, "R5"); push(1'b0, 1'b0, "R5");

    push(1'b1, 1'b0, "R6"); push(1'b0, 1'b0, "R6"); push(1'b1, 1'b1, "R6 bit3");
    push(1'b0, 1'b0, "R6"); push(1'b1, 1'b0, "R6 bit5 no hit");
    push(1'b0, 1'b0, "R6"); push(1'b1, 1'b1, "R6 bit7");
    push(1'b0, 1'b0, "R7");

    push(1'b1, 1'b0, "R8"); push(1'b0, 1'b0, "R8");
    do_reset(1'b1);
    push(1'b1, 1'b0, "R8 after reset"); push(1'b0, 1'b0, "R8");
    push(1'b1, 1'b1, "R8 full match after reset");
    push(1'b0, 1'b0, "R2");

    since_match = 0;
    last3 = 3'b000;
    for (int i = 0; i < RAND_BITS; i++) begin
      bit b;
      bit expv;
      b = 1'($urandom_range(0, 1));
      last3 = {last3[1:0], b};
      since_match++;
      expv = (since_match >= 3) && (last3 == 3'b101);
      if (expv) since_match = 0;
      push(b, expv, "R2 random stream");
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule